// File: doc/BRIEF.md
# Programmable Pulse Train Generator

This block turns one output pin into a counted pulse generator. Software programs a mode word, a timing word X and a count Y. The low half of X sets the length of one base period in clock ticks. The high half of X sets how many ticks at the start of each period the waveform stays low before it goes high. Writing a nonzero Y starts a train of that many periods. When the last period ends, a completion flag rises.

An enable input gates all activity. While enable is low, every counter is cleared and Y writes are dropped. The period timer starts from tick zero in the first cycle that enable is high. Y stays live for the whole run, so a rewrite can stretch or cut short a train that is already running. With X equal to 1 the generator gives a single pulse exactly Y ticks long. A mode bit inverts the pin. When the mode word has its generator bit clear, the block lets go of the pin: the pin then follows the ordinary output register, and the flag shows the raw pin input.

All control inputs are plain one-cycle write strobes. They are taken on the clock edge and never stalled, so there is no back-pressure and no ready signal.

Top module: `ptg_pulse_train`

## Requirements
- R1: The period is X[15:0] ticks. Each active period is split by tick position p, counted from 0: the raw level is 0 while p < X[31:16] and 1 for the rest of the period. If X[31:16] is not less than the period, the raw level stays 0 for the whole period.
- R2: When X[31:16] is 0, the raw level is 1 on every tick of every active period.
- R3: X[15:0] = 0 gives a period of 65536 ticks.
- R4: A Y write of N > 0 while idle starts N active periods, beginning with the period after the one in which the write lands. This holds even when the write lands on the last tick of a period. Whenever no train runs, the raw level is 0.
- R5: The completion flag rises on the first tick after the last active period. A Y write (of any value) clears it, and so does taking enable low.
- R6: Enable is level sensitive. While enable is low, the timer, Y, the busy state and the flag are all zero, and Y writes have no effect. The timer is at tick 0 in the first cycle that enable is high. Holding enable high never restarts the timer.
- R7: Mode bit 1 inverts the pin: pin = raw XOR bit 1. An idle generator therefore drives the value of bit 1.
- R8: With X = 1, a Y write of N makes the pin active on exactly the N ticks that follow the write. Rewriting Y during the pulse sets the number of active ticks remaining after the write, whether that makes the pulse longer or shorter.
- R9: While a train runs, a Y write made before the last tick of a period replaces the number of periods still to run, and the current period counts as one of them.
- R10: When mode bit 0 is clear (the value after reset), the pin equals the ordinary output register input, the flag equals the raw pin input, and enable and Y writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Strobe that loads mode_data |
| mode_data | input | 2 | Bit 0: generator on. Bit 1: invert the pin |
| x_wr | input | 1 | Strobe that loads x_data |
| x_data | input | 2*TW | Low half is the period; high half is the number of low ticks |
| y_wr | input | 1 | Strobe that loads y_data |
| y_data | input | YW | Count of periods |
| en | input | 1 | Enable; while low, the generator is held cleared |
| out_reg | input | 1 | Ordinary output register value, driven out when released |
| pin_in | input | 1 | Raw pin input, passed to the flag when released |
| pin_o | output | 1 | Pin level |
| evt_o | output | 1 | Completion flag, or pin_in when released |

## Verification
Two things can fall on the same clock edge: a Y write and the end of a period. Period end normally decrements Y and decides whether the next period is active, and the write has to take priority over that. The sweep provokes the clash by placing the write both on the first tick and on the last tick of a period, for every small period, low length, count and polarity. The pin and the flag are then compared on every tick against a closed-form schedule in which the train starts with the period after the write. Live rewrites with X = 1 put writes on every edge, since with a one-tick period every edge ends a period. The length of the pulse that results is checked against the count written.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int MODE_W = 2;

  typedef struct packed {
    logic invert;
    logic gen_on;
  } ptg_mode_t;
endpackage

// File: rtl/ptg_period_timer.sv
module ptg_period_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] per_len,
  input  logic [TW-1:0] low_len,
  output logic          period_end,
  output logic          in_high
);
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] tick_q;
  logic [TW-1:0] last_tick;

  // a zero period wraps to all ones, i.e. 2**TW ticks
  assign last_tick  = per_len - ONE;
  assign period_end = run && (tick_q == last_tick);
  assign in_high    = (tick_q >= low_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tick_q <= '0;
    else if (!run || period_end) tick_q <= '0;
    else                        tick_q <= tick_q + ONE;
  end

  AST_TMR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (tick_q == '0)); // R1
  AST_TMR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tick_q == '0)); // R6
endmodule

// File: rtl/ptg_count_ctl.sv
module ptg_count_ctl #(
  parameter int YW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          period_end,
  input  logic          y_wr,
  input  logic [YW-1:0] y_data,
  output logic          busy,
  output logic          evt
);
  localparam logic [YW-1:0] ONE = YW'(1);

  logic [YW-1:0] y_q, y_nx;
  logic          busy_nx, evt_nx;

  always_comb begin
    y_nx    = y_q;
    busy_nx = busy;
    evt_nx  = evt;
    if (period_end && busy && (y_q != '0)) y_nx = y_q - ONE;
    if (y_wr) y_nx = y_data;
    // the state of the next period is decided only at a boundary
    if (period_end) busy_nx = (y_nx != '0);
    if (period_end && busy && (y_nx == '0) && !y_wr) evt_nx = 1'b1;
    if (y_wr) evt_nx = 1'b0;
    if (!run) begin
      y_nx    = '0;
      busy_nx = 1'b0;
      evt_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q  <= '0;
      busy <= 1'b0;
      evt  <= 1'b0;
    end else begin
      y_q  <= y_nx;
      busy <= busy_nx;
      evt  <= evt_nx;
    end
  end

  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((y_q == '0) && !busy && !evt)); // R6
  AST_Y_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !y_wr && !period_end) |=> $stable(y_q)); // R4
  AST_Y_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && y_wr) |=> (y_q == $past(y_data))); // R9
  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (run && y_wr) |=> !evt); // R5
  AST_EVT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt) |-> $past(busy)); // R5
endmodule

// File: rtl/ptg_out_mux.sv
module ptg_out_mux (
  input  logic gen_on,
  input  logic invert,
  input  logic busy,
  input  logic in_high,
  input  logic evt,
  input  logic out_reg,
  input  logic pin_in,
  output logic pin_o,
  output logic evt_o
);
  logic raw_lvl;

  assign raw_lvl = busy && in_high;
  assign pin_o   = gen_on ? (raw_lvl ^ invert) : out_reg;
  assign evt_o   = gen_on ? evt : pin_in;
endmodule

// File: rtl/ptg_pulse_train.sv
module ptg_pulse_train import ptg_pkg::*; #(
  parameter int TW = 16,
  parameter int YW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_data,
  input  logic              x_wr,
  input  logic [2*TW-1:0]   x_data,
  input  logic              y_wr,
  input  logic [YW-1:0]     y_data,
  input  logic              en,
  input  logic              out_reg,
  input  logic              pin_in,
  output logic              pin_o,
  output logic              evt_o
);
  ptg_mode_t     mode_q;
  logic [TW-1:0] per_len_q, low_len_q;
  logic          run, period_end, in_high, busy, evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      per_len_q <= '0;
      low_len_q <= '0;
    end else begin
      if (mode_wr) mode_q <= ptg_mode_t'(mode_data);
      if (x_wr) begin
        per_len_q <= x_data[TW-1:0];
        low_len_q <= x_data[2*TW-1:TW];
      end
    end
  end

  assign run = en && mode_q.gen_on;

  ptg_period_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run),
    .per_len(per_len_q), .low_len(low_len_q),
    .period_end(period_end), .in_high(in_high)
  );

  ptg_count_ctl #(.YW(YW)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .period_end(period_end),
    .y_wr(y_wr), .y_data(y_data), .busy(busy), .evt(evt)
  );

  ptg_out_mux u_mux (
    .gen_on(mode_q.gen_on), .invert(mode_q.invert), .busy(busy),
    .in_high(in_high), .evt(evt), .out_reg(out_reg), .pin_in(pin_in),
    .pin_o(pin_o), .evt_o(evt_o)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.gen_on && !busy) |-> (pin_o == mode_q.invert)); // R4
endmodule

// File: tb/ptg_pulse_train_tb.sv
module ptg_pulse_train_tb;
  localparam int TW = 16;
  localparam int YW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b0, x_wr = 1'b0, y_wr = 1'b0;
  logic [1:0] mode_data = '0;
  logic [2*TW-1:0] x_data = '0;
  logic [YW-1:0] y_data = '0;
  logic en = 1'b0, out_reg = 1'b0, pin_in = 1'b0;
  logic pin_o, evt_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptg_pulse_train #(.TW(TW), .YW(YW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_data(mode_data),
    .x_wr(x_wr), .x_data(x_data), .y_wr(y_wr), .y_data(y_data),
    .en(en), .out_reg(out_reg), .pin_in(pin_in), .pin_o(pin_o), .evt_o(evt_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // disable, then load mode and X; returns at a negedge with en still low
  task automatic setup(input logic inv, input logic [15:0] lo, input logic [15:0] per);
    @(negedge clk);
    en = 1'b0; y_wr = 1'b0;
    mode_wr = 1'b1; mode_data = {inv, 1'b1};
    x_wr = 1'b1; x_data = {lo, per};
    @(negedge clk);
    mode_wr = 1'b0; x_wr = 1'b0;
  endtask

  task automatic sweep_case(input int per, input int lo, input int n, input int w, input logic inv);
    int s;
    int stop;
    string tag;
    s = w / per + 1;
    stop = (s + n) * per;
    if (inv) tag = "R7";
    else if (lo == 0) tag = "R2";
    else if (per == 1) tag = "R8";
    else tag = "R1";
    setup(inv, 16'(lo), 16'(per));
    for (int k = 0; k <= stop + 2; k++) begin
      logic raw;
      @(negedge clk);
      raw = (k >= s * per) && (k < stop) && ((k % per) >= lo);
      chk(tag, pin_o, raw ^ inv);
      chk("R5", evt_o, k >= stop);
      en = 1'b1;
      y_wr = (k == w);
      y_data = YW'(n);
    end
    y_wr = 1'b0;
    en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    out_reg = 1'b1; pin_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", pin_o, 1'b1);
    chk("R10", evt_o, 1'b0);
    rst_n = 1'b1;

    // R10: released pin follows out_reg / pin_in, enable and Y ignored
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      out_reg = c[0]; pin_in = c[1]; en = 1'b1; y_wr = 1'b1; y_data = 32'd3;
      @(negedge clk);
      y_wr = 1'b0;
      chk("R10", pin_o, c[0]);
      chk("R10", evt_o, c[1]);
    end
    en = 1'b0; out_reg = 1'b0; pin_in = 1'b1;

    // R1 R2 R7 R8 R5 R4: sweep; writes on first and last tick of a period
    for (int per = 1; per <= 4; per++)
      for (int lo = 0; lo <= per + 1; lo++)
        for (int n = 1; n <= 3; n++)
          for (int wi = 0; wi < 2; wi++)
            for (int iv = 0; iv < 2; iv++)
              sweep_case(per, lo, n, (wi == 0) ? 0 : per - 1, iv[0]);

    // R6: Y write while disabled is dropped; R4: enabled idle drives 0
    setup(1'b0, 16'd0, 16'd2);
    y_wr = 1'b1; y_data = 32'd3;
    @(negedge clk);
    y_wr = 1'b0; en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R6", evt_o, 1'b0);
      chk("R4", pin_o, 1'b0);
    end

    // R6: dropping enable clears the flag
    setup(1'b0, 16'd0, 16'd1);
    en = 1'b1; y_wr = 1'b1; y_data = 32'd1;
    @(negedge clk); y_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5", evt_o, 1'b1);
    en = 1'b0;
    @(negedge clk);
    chk("R6", evt_o, 1'b0);

    // R8: shorten live pulse, Y=5 at k0, Y=1 at k2 -> active k1..k3
    setup(1'b0, 16'd0, 16'd1);
    for (int k = 0; k <= 6; k++) begin
      @(negedge clk);
      chk("R8", pin_o, (k >= 1) && (k <= 3));
      chk("R8", evt_o, k >= 4);
      en = 1'b1;
      y_wr = (k == 0) || (k == 2);
      y_data = (k == 0) ? 32'd5 : 32'd1;
    end
    y_wr = 1'b0;

    // R8: lengthen live pulse, Y=2 at k0, Y=6 at k1 -> active k1..k7
    setup(1'b0, 16'd0, 16'd1);
    for (int k = 0; k <= 10; k++) begin
      @(negedge clk);
      chk("R8", pin_o, (k >= 1) && (k <= 7));
      chk("R8", evt_o, k >= 8);
      en = 1'b1;
      y_wr = (k <= 1);
      y_data = (k == 0) ? 32'd2 : 32'd6;
    end
    y_wr = 1'b0;

    // R9: period 4, low 1, Y=3 at k0, Y=1 at k9 -> active k4..k11
    // R5: Y=0 written at k16 clears the flag from k17
    setup(1'b0, 16'd1, 16'd4);
    for (int k = 0; k <= 19; k++) begin
      @(negedge clk);
      chk("R9", pin_o, (k >= 4) && (k <= 11) && ((k % 4) >= 1));
      chk("R5", evt_o, (k >= 12) && (k <= 16));
      en = 1'b1;
      y_wr = (k == 0) || (k == 9) || (k == 16);
      y_data = (k == 0) ? 32'd3 : ((k == 9) ? 32'd1 : 32'd0);
    end
    y_wr = 1'b0;

    // R3: period field 0 -> 65536 ticks; train starts at tick 65536
    setup(1'b0, 16'd0, 16'd0);
    for (int k = 0; k <= 65537; k++) begin
      @(negedge clk);
      if (k == 65535) chk("R3", pin_o, 1'b0);
      if (k == 65536) chk("R3", pin_o, 1'b1);
      if (k == 65537) chk("R3", evt_o, 1'b0);
      en = 1'b1;
      y_wr = (k == 0);
      y_data = 32'd1;
    end
    y_wr = 1'b0; en = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule